// File: doc/BRIEF.md
# Watchdog Timer with Reset Control

This block is an 8-bit watchdog timer. A free-running divider produces a tick enable every `TICK_DIV` clocks. While the timer is enabled, each tick advances the counter by one.

When the counter passes 0xFF it overflows, and the effect depends on the mode:

- **Interval mode:** the overflow sets an interrupt flag, the interrupt output follows that flag, and the count wraps to zero.
- **Watchdog mode:** the overflow sets a sticky flag in the reset control/status register. It also clears the counter and the timer control register. If reset enable is set, it additionally drives a pulse of fixed length on the internal reset output.

Software reaches three registers over a plain single-cycle read/write bus.

The reset control/status register is kept apart from the block's own internal reset. Only the external asynchronous reset or a standby-entry strobe returns it to 0x1F. Its overflow flag can only be cleared by a read that returns bit 7 as 1, followed by a write of 0 to bit 7. This lets software see, after a restart, that the watchdog fired.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is asserted, the reset control/status register (address 2) reads 0x1F, the timer control register (address 0) and the counter (address 1) read 0x00, and `irq_o` and `wdt_rst_o` are 0. Address 3 reads 0x00.
- R2: The timer control register holds three bits: interrupt flag in bit 7, mode in bit 6 (1 = watchdog, 0 = interval) and timer enable in bit 5; bits 4..0 read 0. While enable is 1, the counter rises by exactly 1 per tick (one tick every `TICK_DIV` = 4 clocks) and wraps from 0xFF to 0x00. While enable is 0, the counter holds its value.
- R3: An overflow in interval mode does three things: it sets timer control bit 7, `irq_o` follows that bit, and the count wraps. It never sets the overflow flag and never pulses `wdt_rst_o`, whatever reset enable holds.
- R4: An overflow in watchdog mode sets reset control/status bit 7, and on the following cycle the counter and the whole timer control register read 0.
- R5: When reset enable (reset control/status bit 6) is 1, each watchdog-mode overflow drives `wdt_rst_o` high for exactly 4 consecutive clocks, starting at the same edge that sets the overflow flag.
- R6: When reset enable is 0, a watchdog-mode overflow leaves `wdt_rst_o` low, but the counter and the timer control register are still cleared.
- R7: Overflow flag clearing has four rules:
  - The flag clears only when a write of 0 to bit 7 follows a read of the register that returned bit 7 as 1.
  - Every write to the register consumes that read qualifier.
  - A write of 0 with no qualifying read leaves the flag set.
  - Writing 1 never changes the flag.
- R8: In the reset control/status register, bits 4..0 always read 1 and ignore writes. Bits 6 (reset enable) and 5 (reset select) are read/write, and bit 5 also drives `rst_sel_o`.
- R9: The internal reset pulse leaves the reset control/status register unchanged. Only `rst_ni` low or `standby_i` high at a clock edge returns it to 0x1F and clears the read qualifier.
- R10: Writing 0 to timer control bit 7 clears the interrupt flag and drops `irq_o`. Writing 1 there has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low external reset |
| standby_i | input | 1 | Standby-entry strobe; reinitialises the reset control/status register |
| bus_re_i | input | 1 | Read strobe |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Register address: 0 timer control, 1 counter, 2 reset control/status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from address |
| irq_o | output | 1 | Interval-overflow interrupt |
| wdt_rst_o | output | 1 | Internal reset pulse |
| rst_sel_o | output | 1 | Stored reset-select bit |

## Verification
The assertions assume the following about the inputs:
- A read and a write never share a cycle.
- A bus write to the counter or the timer control register never lands in the same cycle as a watchdog-mode overflow.
- `standby_i` is not raised in the cycle of an overflow.

The stimulus keeps to this as follows:
- It issues one access at a time, each spanning a single clock.
- It programs the counter before enabling the timer.
- It touches the timer registers only after an overflow has already been observed, or while the timer is disabled.
- It pulses standby only while the counter is stopped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam logic [1:0] ADDR_TCTL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_RCSR = 2'd2;
  localparam logic [DATA_W-1:0] RCSR_INIT = 8'h1F;

  typedef struct packed {
    logic itf;      // interval overflow flag
    logic wd_mode;  // 1 = watchdog
    logic en;       // timer enable
  } tctl_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_tctl_i,
  input  logic              wr_cnt_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output tctl_t             tctl_o,
  output logic              ovf_wd_o,
  output logic              ovf_int_o
);
  logic [CNT_W-1:0] cnt_q;
  tctl_t            tctl_q;
  logic             ovf_raw;

  assign ovf_raw   = tick_i & tctl_q.en & (&cnt_q);
  assign ovf_wd_o  = ovf_raw & tctl_q.wd_mode;
  assign ovf_int_o = ovf_raw & ~tctl_q.wd_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (ovf_wd_o)             cnt_q <= '0;
    else if (wr_cnt_i)             cnt_q <= wdata_i[CNT_W-1:0];
    else if (tick_i && tctl_q.en)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tctl_q <= '0;
    else if (ovf_wd_o) tctl_q <= '0;
    else begin
      if (wr_tctl_i) begin
        tctl_q.wd_mode <= wdata_i[6];
        tctl_q.en      <= wdata_i[5];
        if (!wdata_i[7]) tctl_q.itf <= 1'b0;
      end
      if (ovf_int_o) tctl_q.itf <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign tctl_o = tctl_q;

  // R2
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && tctl_q.en && !(&cnt_q) && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  wd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_wd_o |=> (cnt_q == '0 && tctl_q == '0));
endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
  import wdog_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              ovf_wd_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        wdata_hi_i,
  output logic [DATA_W-1:0] rcsr_o,
  output logic              wdt_rst_o,
  output logic              rst_sel_o
);
  localparam int PW = $clog2(RST_CYC + 1);

  logic          ovf_q, rste_q, rsts_q, qual_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0; rste_q <= 1'b0; rsts_q <= 1'b0; qual_q <= 1'b0;
    end else if (standby_i) begin
      ovf_q <= 1'b0; rste_q <= 1'b0; rsts_q <= 1'b0; qual_q <= 1'b0;
    end else begin
      if (wr_i) begin
        rste_q <= wdata_hi_i[1];
        rsts_q <= wdata_hi_i[0];
        qual_q <= 1'b0;
      end else if (rd_i && ovf_q) begin
        qual_q <= 1'b1;
      end
      if (ovf_wd_i) ovf_q <= 1'b1;
      else if (wr_i && qual_q && !wdata_hi_i[2]) ovf_q <= 1'b0;
    end
  end

  // pulse counter is not touched by standby; it only drives the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pcnt_q <= '0;
    else if (ovf_wd_i && rste_q) pcnt_q <= PW'(RST_CYC);
    else if (pcnt_q != '0)      pcnt_q <= pcnt_q - 1'b1;
  end

  assign wdt_rst_o = (pcnt_q != '0);
  assign rst_sel_o = rsts_q;
  assign rcsr_o    = {ovf_q, rste_q, rsts_q, 5'b11111};

  // R7
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !qual_q && ovf_q && !standby_i) |=> ovf_q);
  // R5
  rst_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wdt_rst_o) && !$past(standby_i)) |-> ovf_q);
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 8,
  parameter int RST_CYC  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        standby_i,
  input  logic        bus_re_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        irq_o,
  output logic        wdt_rst_o,
  output logic        rst_sel_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  tctl_t            tctl;
  logic             ovf_wd, ovf_int;
  logic [DATA_W-1:0] rcsr;

  wdog_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick));

  wdog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .wr_tctl_i(bus_we_i && bus_addr_i == ADDR_TCTL),
    .wr_cnt_i (bus_we_i && bus_addr_i == ADDR_CNT),
    .wdata_i(bus_wdata_i), .cnt_o(cnt), .tctl_o(tctl),
    .ovf_wd_o(ovf_wd), .ovf_int_o(ovf_int));

  wdog_rstctl #(.RST_CYC(RST_CYC)) u_rstctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i),
    .ovf_wd_i(ovf_wd),
    .rd_i(bus_re_i && bus_addr_i == ADDR_RCSR),
    .wr_i(bus_we_i && bus_addr_i == ADDR_RCSR),
    .wdata_hi_i(bus_wdata_i[7:5]),
    .rcsr_o(rcsr), .wdt_rst_o(wdt_rst_o), .rst_sel_o(rst_sel_o));

  always_comb begin
    case (bus_addr_i)
      ADDR_TCTL: bus_rdata_o = {tctl.itf, tctl.wd_mode, tctl.en, 5'b0};
      ADDR_CNT:  bus_rdata_o = DATA_W'(cnt);
      ADDR_RCSR: bus_rdata_o = rcsr;
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o = tctl.itf;

  // R3
  int_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_int && !rcsr[7]) |=> !rcsr[7]);
  // R3
  int_no_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_int && !wdt_rst_o) |=> !wdt_rst_o);
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
  logic re = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, wrst, rsel;

  always #4 clk = ~clk;

  wdog_top dut (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby),
    .bus_re_i(re), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .wdt_rst_o(wrst), .rst_sel_o(rsel));

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  int total = 0, bad = 0;
  bit cap_on = 0;
  logic [7:0] cap_val;
  int run = 0, last_w = 0, pulses = 0;

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (re && !cap_on) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++; $display("FAIL %s: unexpected read act=%h", "R1", rdata);
      end else begin
        e = sb_q.pop_front();
        if (rdata !== e.exp) begin
          bad++; $display("FAIL %s act=%h exp=%h", e.tag, rdata, e.exp);
        end
      end
    end
  end

  // reset pulse width monitor
  always @(negedge clk) begin
    if (wrst) run++;
    else if (run != 0) begin last_w = run; pulses++; run = 0; end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    re = 1'b1; addr = a;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic rd_get(input logic [1:0] a);
    cap_on = 1; re = 1'b1; addr = a;
    @(negedge clk); cap_val = rdata;
    @(posedge clk); #1 re = 1'b0; cap_on = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v0;
    int n;
    idle(3); rst_n = 1'b1; idle(1);
    // R1 reset state
    rd(2'd2, 8'h1F, "R1 rcsr");
    rd(2'd0, 8'h00, "R1 tctl");
    rd(2'd1, 8'h00, "R1 cnt");
    rd(2'd3, 8'h00, "R1 unused");
    chk({7'd0, irq}, 8'd0, "R1 irq");
    chk({7'd0, wrst}, 8'd0, "R1 wdt_rst");

    // R8 field access
    wr(2'd2, 8'h00); rd(2'd2, 8'h1F, "R8 low bits fixed");
    wr(2'd2, 8'h60); rd(2'd2, 8'h7F, "R8 rw bits");
    chk({7'd0, rsel}, 8'd1, "R8 rst_sel_o");
    wr(2'd2, 8'hFF); rd(2'd2, 8'h7F, "R7 write1 no set");
    wr(2'd2, 8'h40); rd(2'd2, 8'h5F, "R8 bit5 clear");
    chk({7'd0, rsel}, 8'd0, "R8 rst_sel_o low");

    // R2 counting
    wr(2'd1, 8'h10); wr(2'd0, 8'h20);
    rd_get(2'd1); v0 = cap_val;
    idle(15);
    rd(2'd1, v0 + 8'd4, "R2 four ticks in 16 clocks");
    wr(2'd0, 8'h00);
    rd_get(2'd1); v0 = cap_val;
    idle(20);
    rd(2'd1, v0, "R2 hold when disabled");

    // R3 interval overflow, reset enable set but ignored
    wr(2'd1, 8'hFE); wr(2'd0, 8'h20);
    n = 0;
    while (!irq && n < 200) begin idle(1); n++; end
    chk({7'd0, irq}, 8'd1, "R3 irq raised");
    rd(2'd0, 8'hA0, "R3 tctl flag");
    rd(2'd2, 8'h5F, "R3 no ovf flag");
    rd_get(2'd1);
    chk({7'd0, cap_val < 8'd4}, 8'd1, "R3 count wrapped");
    idle(10);
    chk(8'(pulses), 8'd0, "R3 no reset pulse");

    // R10 flag clear
    wr(2'd0, 8'hA0); rd(2'd0, 8'hA0, "R10 write1 keeps flag");
    wr(2'd0, 8'h00); rd(2'd0, 8'h00, "R10 clear");
    chk({7'd0, irq}, 8'd0, "R10 irq low");

    // R4 R5 R9 watchdog overflow with reset enable
    wr(2'd1, 8'hFC); wr(2'd0, 8'h60);
    n = 0;
    while (!wrst && n < 200) begin idle(1); n++; end
    idle(10);
    chk(8'(pulses), 8'd1, "R5 one pulse");
    chk(8'(last_w), 8'd4, "R5 pulse width");
    rd(2'd2, 8'hDF, "R4 R9 flag set, rcsr kept");
    rd(2'd0, 8'h00, "R4 tctl cleared");
    rd(2'd1, 8'h00, "R4 cnt cleared");

    // R7 clear protocol (previous read set the qualifier)
    wr(2'd2, 8'hC0);                         // consumes qualifier
    wr(2'd2, 8'h40);                         // 0 without read
    rd(2'd2, 8'hDF, "R7 no clear without read");
    wr(2'd2, 8'h40);
    rd(2'd2, 8'h5F, "R7 clear after read");

    // R6 reset enable off
    wr(2'd2, 8'h20); rd(2'd2, 8'h3F, "R6 setup");
    wr(2'd1, 8'hFC); wr(2'd0, 8'h60);
    idle(40);
    rd(2'd2, 8'hBF, "R6 flag set");
    rd(2'd0, 8'h00, "R6 tctl cleared");
    rd(2'd1, 8'h00, "R6 cnt cleared");
    chk(8'(pulses), 8'd1, "R6 no new pulse");

    // R9 standby restores
    standby = 1'b1; idle(1); standby = 1'b0;
    rd(2'd2, 8'h1F, "R9 standby init");
    chk({7'd0, rsel}, 8'd0, "R9 rst_sel_o");
    // R9 external reset restores
    wr(2'd2, 8'h60);
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
    rd(2'd2, 8'h1F, "R9 pin reset init");

    idle(2);
    finish_run();
  end
endmodule